// File: doc/BRIEF.md
# Time-Division-Multiplexed Serial Audio Port

This block moves audio samples between a parallel, slot-indexed word interface and a four-line serial link: bit clock, frame sync, transmit data and receive data. Each frame is split into a configurable number of equal-width time slots, so several devices can share the same lines, each driving and listening only in the slots it owns. The transmit pin carries an output enable that is low outside owned slots, which lets a neighbour drive the shared wire there.

As bit-clock master, the port divides the system clock to make the bit clock and emits a sync pulse one bit period wide once per frame. As a slave, it follows an external bit clock and sync line, both oversampled by the system clock. A mode input chooses where the sync sits relative to the first slot. In one alignment the sync occupies the first bit period, together with the most significant bit of slot 0. In the other it occupies the last bit period of the previous frame, so the most significant bit leaves on the next falling edge. In slave mode, a sync at an unexpected bit position re-aligns the frame and raises a framing-error pulse.

The transmit side shows the index of the slot it is about to launch and samples the word for that slot on the launching edge. The receive side hands over each completed word together with its slot index. The configuration inputs are meant to be changed only while the block is held in reset.

Top module: `tdm_serial_port`

## Requirements
- R1: As master the bit clock output is low for BCLK_HALF system clocks and then high for BCLK_HALF, so falling edges come every 2*BCLK_HALF clocks. As slave, bclk_o and fsync_o stay low.
- R2: As master, fsync_o is high for exactly one bit period per frame of frame_bits_i bit periods. In mode B (mode_b_i=1) that is bit period 0. In mode A (mode_b_i=0) it is bit period frame_bits_i-1.
- R3: Bit period p, counted from the falling edge where the frame begins, belongs to slot p/slot_bits_i and to bit p%slot_bits_i of that slot. Bits leave MSB first and take the low slot_bits_i bits of the word. Serial output changes only where bclk_o falls.
- R4: tx_oe_o is high during the whole of slot n exactly when n < num_slots_i and tx_own_i[n]=1. Otherwise it is low and tx_sd_o is 0. The idle bit periods beyond num_slots_i*slot_bits_i are never owned.
- R5: tx_take_o pulses once for each owned slot, in the cycle of the falling edge that launches its MSB. tx_slot_o names that slot, and tx_word_i is sampled in the same cycle.
- R6: Receive data is sampled at rising bit-clock edges. After the last bit of slot n, with n < num_slots_i and rx_own_i[n]=1, rx_valid_o pulses for one clock. It comes with rx_slot_o=n and rx_word_o holding the slot's bits right-aligned, MSB first. No pulse is given for slots that are not owned.
- R7: As slave, the port follows bclk_i and samples fsync_i at its rising edges. A sync at the expected position gives no error. This holds for bit period frame_bits_i-1 (or before the first frame) in mode A, and for bit period 0 in mode B. A sync at any other position pulses frame_err_o for one clock. The next falling edge then begins bit period 0 in mode A or bit period 1 in mode B.
- R8: In reset, bclk_o, tx_oe_o, tx_sd_o, tx_take_o, rx_valid_o and frame_err_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1: generate bit clock and sync; 0: follow them |
| mode_b_i | input | 1 | 1: sync coincident with slot 0 MSB; 0: sync one bit earlier |
| num_slots_i | input | $clog2(MAX_SLOTS+1) | Slots per frame |
| slot_bits_i | input | $clog2(DATA_W+1) | Bits per slot |
| frame_bits_i | input | $clog2(MAX_FRAME+1) | Bit periods per frame |
| tx_own_i | input | MAX_SLOTS | Transmit slot ownership mask |
| rx_own_i | input | MAX_SLOTS | Receive slot ownership mask |
| bclk_i | input | 1 | External bit clock (slave) |
| fsync_i | input | 1 | External frame sync (slave) |
| bclk_o | output | 1 | Generated bit clock (master) |
| fsync_o | output | 1 | Generated frame sync (master) |
| tx_sd_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Transmit output enable |
| rx_sd_i | input | 1 | Serial receive data |
| tx_slot_o | output | $clog2(MAX_SLOTS) | Index of the slot about to be launched |
| tx_word_i | input | DATA_W | Word for the slot named by tx_slot_o |
| tx_take_o | output | 1 | tx_word_i consumed this cycle |
| rx_word_o | output | DATA_W | Received word, right-aligned |
| rx_slot_o | output | $clog2(MAX_SLOTS) | Slot index of rx_word_o |
| rx_valid_o | output | 1 | rx_word_o and rx_slot_o are new |
| frame_err_o | output | 1 | Sync seen at an unexpected position |

## Verification
Bit-period state (sync, enable, serial bit) is registered on the system clock edge that carries the falling bit-clock event. It is therefore checked at the first system-clock falling edge after bclk_o or bclk_i is seen low, and it holds for the whole bit period. Received words appear one clock after the rising edge that sampled their last bit. The bench watches rx_valid_o on every clock and collects pulses rather than waiting for a fixed cycle, and it counts tx_take_o the same way. Framing errors in slave mode are gathered over the bit period in which the misplaced sync is sampled. Realignment is then judged from the output enable over the slots that follow.

// File: rtl/tdm_serial_port.sv
module tdm_serial_port #(
  parameter int MAX_SLOTS = 8,
  parameter int DATA_W    = 32,
  parameter int MAX_FRAME = 256,
  parameter int BCLK_HALF = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             master_i,
  input  logic                             mode_b_i,
  input  logic [$clog2(MAX_SLOTS+1)-1:0]   num_slots_i,
  input  logic [$clog2(DATA_W+1)-1:0]      slot_bits_i,
  input  logic [$clog2(MAX_FRAME+1)-1:0]   frame_bits_i,
  input  logic [MAX_SLOTS-1:0]             tx_own_i,
  input  logic [MAX_SLOTS-1:0]             rx_own_i,
  input  logic                             bclk_i,
  input  logic                             fsync_i,
  output logic                             bclk_o,
  output logic                             fsync_o,
  output logic                             tx_sd_o,
  output logic                             tx_oe_o,
  input  logic                             rx_sd_i,
  output logic [$clog2(MAX_SLOTS)-1:0]     tx_slot_o,
  input  logic [DATA_W-1:0]                tx_word_i,
  output logic                             tx_take_o,
  output logic [DATA_W-1:0]                rx_word_o,
  output logic [$clog2(MAX_SLOTS)-1:0]     rx_slot_o,
  output logic                             rx_valid_o,
  output logic                             frame_err_o
);
  localparam int SW = $clog2(MAX_SLOTS+1);
  localparam int IW = $clog2(MAX_SLOTS);
  localparam int FW = $clog2(MAX_FRAME+1);
  localparam int BW = $clog2(DATA_W+1);
  localparam int DW = $clog2(BCLK_HALF+1);
  localparam logic [BW-1:0] DATA_W_B = BW'(DATA_W);

  logic [DW-1:0]     div_q;
  logic              bclk_q, bclk_in_q, resync_q, oe_q;
  logic [FW-1:0]     pos_q, n_pos;
  logic [SW-1:0]     slot_q, n_slot;
  logic [BW-1:0]     bit_q, n_bit;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q, rx_nxt;

  wire tick = master_i && (div_q == DW'(BCLK_HALF-1));
  wire rise = master_i ? (tick && !bclk_q) : (bclk_i && !bclk_in_q);
  wire fall = master_i ? (tick && bclk_q)  : (!bclk_i && bclk_in_q);

  wire [FW-1:0] last_pos = frame_bits_i - FW'(1);
  wire [BW-1:0] last_bit = slot_bits_i - BW'(1);
  wire          pre      = &pos_q;
  wire          sync_ok  = mode_b_i ? (pos_q == '0) : (pos_q == last_pos || pre);
  wire          sync_in  = !master_i && rise && fsync_i;

  wire n_txown = (n_slot < num_slots_i) && tx_own_i[n_slot[IW-1:0]];
  wire c_rxown = (slot_q < num_slots_i) && rx_own_i[slot_q[IW-1:0]];

  always_comb begin
    n_pos  = pos_q;
    n_slot = slot_q;
    n_bit  = bit_q;
    if (resync_q) begin
      n_pos  = mode_b_i ? FW'(1) : '0;
      n_slot = (mode_b_i && slot_bits_i == BW'(1)) ? SW'(1) : '0;
      n_bit  = (mode_b_i && slot_bits_i != BW'(1)) ? BW'(1) : '0;
    end else if (pre || pos_q >= last_pos) begin
      n_pos  = '0;
      n_slot = '0;
      n_bit  = '0;
    end else begin
      n_pos = pos_q + FW'(1);
      if (bit_q == last_bit) begin
        n_bit  = '0;
        n_slot = (slot_q == SW'(MAX_SLOTS)) ? slot_q : slot_q + SW'(1);
      end else begin
        n_bit = bit_q + BW'(1);
      end
    end
  end

  assign rx_nxt    = (bit_q == '0) ? DATA_W'(rx_sd_i) : {rx_sh_q[DATA_W-2:0], rx_sd_i};
  assign bclk_o    = master_i && bclk_q;
  assign fsync_o   = master_i && (mode_b_i ? (pos_q == '0) : (pos_q == last_pos || pre));
  assign tx_oe_o   = oe_q;
  assign tx_sd_o   = oe_q && tx_sh_q[DATA_W-1];
  assign tx_slot_o = n_slot[IW-1:0];
  assign tx_take_o = fall && (n_bit == '0) && n_txown;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q       <= '0;
      bclk_q      <= 1'b0;
      bclk_in_q   <= 1'b0;
      resync_q    <= 1'b0;
      pos_q       <= '1;
      slot_q      <= '1;
      bit_q       <= '0;
      oe_q        <= 1'b0;
      tx_sh_q     <= '0;
      rx_sh_q     <= '0;
      rx_word_o   <= '0;
      rx_slot_o   <= '0;
      rx_valid_o  <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      div_q       <= tick || !master_i ? '0 : div_q + DW'(1);
      bclk_in_q   <= bclk_i;
      rx_valid_o  <= 1'b0;
      frame_err_o <= 1'b0;
      if (tick) bclk_q <= !bclk_q;
      if (rise) begin
        if (sync_in) begin
          resync_q    <= 1'b1;
          frame_err_o <= !sync_ok;
        end
        if (c_rxown) begin
          rx_sh_q <= rx_nxt;
          if (bit_q == last_bit) begin
            rx_valid_o <= 1'b1;
            rx_word_o  <= rx_nxt;
            rx_slot_o  <= slot_q[IW-1:0];
          end
        end
      end
      if (fall) begin
        resync_q <= 1'b0;
        pos_q    <= n_pos;
        slot_q   <= n_slot;
        bit_q    <= n_bit;
        oe_q     <= n_txown;
        tx_sh_q  <= (n_bit == '0) ? (tx_word_i << (DATA_W_B - slot_bits_i)) : (tx_sh_q << 1);
      end
    end
  end
endmodule

// File: rtl/tdm_serial_port_chk.sv
module tdm_serial_port_chk #(
  parameter int MAX_SLOTS = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         master_i,
  input logic                         bclk_o,
  input logic                         fsync_o,
  input logic                         tx_sd_o,
  input logic                         tx_oe_o,
  input logic                         tx_take_o,
  input logic [MAX_SLOTS-1:0]         tx_own_i,
  input logic [$clog2(MAX_SLOTS)-1:0] tx_slot_o,
  input logic                         rx_valid_o,
  input logic                         frame_err_o
);
  AST_SLAVE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !master_i |-> (!bclk_o && !fsync_o)); // R1
  AST_SD_QUIET_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_oe_o |-> !tx_sd_o); // R4
  AST_SD_MOVES_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && !$stable(tx_sd_o)) |-> ($past(bclk_o) && !bclk_o)); // R3
  AST_TAKE_OWNED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take_o |-> tx_own_i[tx_slot_o]); // R5
  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o); // R6
  AST_ERR_SLAVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> !master_i); // R7
endmodule

bind tdm_serial_port tdm_serial_port_chk #(.MAX_SLOTS(MAX_SLOTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .master_i(master_i), .bclk_o(bclk_o), .fsync_o(fsync_o),
  .tx_sd_o(tx_sd_o), .tx_oe_o(tx_oe_o), .tx_take_o(tx_take_o), .tx_own_i(tx_own_i),
  .tx_slot_o(tx_slot_o), .rx_valid_o(rx_valid_o), .frame_err_o(frame_err_o)
);

// File: tb/tdm_serial_port_tb_top.sv
module tdm_serial_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  typedef struct packed {
    logic [3:0] slots;
    logic [5:0] width;
    logic [8:0] frame;
    logic [7:0] txm;
    logic [7:0] rxm;
    logic       modeb;
  } cfg_t;

  localparam cfg_t VEC [6] = '{
    '{4'd8, 6'd8,  9'd64,  8'hA5, 8'h5A, 1'b0},
    '{4'd4, 6'd16, 9'd64,  8'h03, 8'h0C, 1'b1},
    '{4'd2, 6'd32, 9'd80,  8'h01, 8'h02, 1'b0},
    '{4'd3, 6'd1,  9'd8,   8'h05, 8'h02, 1'b1},
    '{4'd8, 6'd24, 9'd192, 8'hFF, 8'hFF, 1'b1},
    '{4'd1, 6'd32, 9'd32,  8'hFF, 8'hFF, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic master_i = 1, mode_b_i = 0, bclk_i = 0, fsync_i = 0, rx_sd_i = 0;
  logic [3:0] num_slots_i = 4'd8;
  logic [5:0] slot_bits_i = 6'd8;
  logic [8:0] frame_bits_i = 9'd64;
  logic [7:0] tx_own_i = '0, rx_own_i = '0;
  logic bclk_o, fsync_o, tx_sd_o, tx_oe_o, tx_take_o, rx_valid_o, frame_err_o;
  logic [2:0] tx_slot_o, rx_slot_o;
  logic [31:0] tx_word_i, rx_word_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] tx_raw(int s);
    return 32'hA5C3_0F96 ^ (s * 32'h1357_9BDF);
  endfunction
  function automatic logic [31:0] rx_raw(int s);
    return 32'h6B1D_E2F7 + s * 32'h0101_0101;
  endfunction
  function automatic logic [31:0] fit(logic [31:0] v, int w);
    return (w >= 32) ? v : (v & ((32'h1 << w) - 1));
  endfunction

  assign tx_word_i = tx_raw(int'(tx_slot_o));

  tdm_serial_port #(.MAX_SLOTS(8), .DATA_W(32), .MAX_FRAME(256), .BCLK_HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .master_i(master_i), .mode_b_i(mode_b_i),
    .num_slots_i(num_slots_i), .slot_bits_i(slot_bits_i), .frame_bits_i(frame_bits_i),
    .tx_own_i(tx_own_i), .rx_own_i(rx_own_i), .bclk_i(bclk_i), .fsync_i(fsync_i),
    .bclk_o(bclk_o), .fsync_o(fsync_o), .tx_sd_o(tx_sd_o), .tx_oe_o(tx_oe_o),
    .rx_sd_i(rx_sd_i), .tx_slot_o(tx_slot_o), .tx_word_i(tx_word_i), .tx_take_o(tx_take_o),
    .rx_word_o(rx_word_o), .rx_slot_o(rx_slot_o), .rx_valid_o(rx_valid_o),
    .frame_err_o(frame_err_o));

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset outputs low", {bclk_o, tx_oe_o, tx_sd_o, tx_take_o, rx_valid_o, frame_err_o}, 0);
    rst_n = 1;
  endtask

  task automatic run_master(input cfg_t c);
    int F, W, S, falls, last_cyc, cyc, takes, words, p, s, b;
    bit prev_b, exp_oe, exp_sd, bad_sync, bad_oe, bad_sd;
    F = int'(c.frame); W = int'(c.width); S = int'(c.slots);
    master_i = 1; mode_b_i = c.modeb; num_slots_i = c.slots; slot_bits_i = c.width;
    frame_bits_i = c.frame; tx_own_i = c.txm; rx_own_i = c.rxm; rx_sd_i = 0;
    do_reset();
    falls = 0; last_cyc = 0; cyc = 0; takes = 0; words = 0; prev_b = 0;
    bad_sync = 0; bad_oe = 0; bad_sd = 0;
    while (falls <= 2 * F) begin
      @(negedge clk);
      cyc++;
      if (tx_take_o && falls < 2 * F) takes++;
      if (rx_valid_o) begin
        words++;
        chk("R6 rx slot owned", rx_own_i[rx_slot_o] && int'(rx_slot_o) < S, 1);
        chk("R6 rx word", rx_word_o, fit(rx_raw(int'(rx_slot_o)), W));
      end
      if (prev_b && !bclk_o) begin
        if (falls == 1) chk("R1 bclk fall spacing", cyc - last_cyc, 2 * HALF);
        last_cyc = cyc;
        p = falls % F; s = p / W; b = p % W;
        exp_oe = (s < S) && c.txm[s % 8];
        exp_sd = exp_oe && fit(tx_raw(s), W)[W-1-b];
        if (fsync_o != (c.modeb ? (p == 0) : (p == F - 1))) bad_sync = 1;
        if (tx_oe_o != exp_oe) bad_oe = 1;
        if (tx_sd_o != exp_sd) bad_sd = 1;
        rx_sd_i = (s < S) ? fit(rx_raw(s), W)[W-1-b] : 1'b0;
        falls++;
      end
      prev_b = bclk_o;
    end
    repeat (3) begin
      @(negedge clk);
      if (rx_valid_o) words++;
    end
    chk("R2 sync position and width", bad_sync, 0);
    chk("R4 output enable per owned slot", bad_oe, 0);
    chk("R3 serial bit order and slot position", bad_sd, 0);
    chk("R5 tx take count", takes, 2 * $countones(c.txm & ((9'h1 << S) - 1)));
    chk("R6 rx word count", words, 2 * $countones(c.rxm & ((9'h1 << S) - 1)));
  endtask

  task automatic sbit(input logic sync, input logic exp_oe, inout bit err, inout bit oe_bad);
    bclk_i = 0; fsync_i = sync;
    repeat (HALF * 2) begin @(negedge clk); err |= frame_err_o; end
    if (tx_oe_o != exp_oe) oe_bad = 1;
    bclk_i = 1;
    repeat (HALF * 2) begin @(negedge clk); err |= frame_err_o; end
  endtask

  task automatic run_slave();
    bit err, oe_bad;
    master_i = 0; mode_b_i = 0; num_slots_i = 4; slot_bits_i = 8; frame_bits_i = 32;
    tx_own_i = 8'h01; rx_own_i = 8'h00; bclk_i = 0; fsync_i = 0; rx_sd_i = 0;
    do_reset();
    err = 0; oe_bad = 0;
    fsync_i = 1; bclk_i = 1;
    repeat (HALF * 2) begin @(negedge clk); err |= frame_err_o; end
    chk("R1 slave leaves bclk_o and fsync_o low", {bclk_o, fsync_o}, 0);
    for (int p = 0; p < 32; p++) sbit(p == 31, p < 8, err, oe_bad);
    chk("R7 aligned sync gives no error", err, 0);
    chk("R7 slave follows external clock", oe_bad, 0);
    err = 0;
    for (int p = 0; p < 10; p++) sbit(p == 9, p < 8, err, oe_bad);
    chk("R7 misplaced sync flags error", err, 1);
    err = 0;
    for (int p = 0; p < 32; p++) sbit(p == 31, p < 8, err, oe_bad);
    chk("R7 realigned frame after error", oe_bad, 0);
    chk("R7 no error after realignment", err, 0);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) run_master(VEC[i]);
    run_slave();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R7 watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule